// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches a port of general-purpose input pins and raises a single GPIO interrupt request toward the interrupt controller. Each pin can be an interrupt source. Each pin has an enable bit and an edge-select bit of its own. A 0 in the edge-select bit arms the pin for a high-to-low transition. A 1 arms it for a low-to-high transition. The pins are asynchronous to the block clock, so each one passes through a two-stage synchronizer before edge detection.

A pin reaches the request only when its own enable bit and the controller's global GPIO enable are both set. The qualified edges of all pins are OR-ed into one sticky request. The request stays high until the controller pulses the clear input. If a new qualified edge arrives in the same cycle as a clear, the request stays set, so no event is lost. Software reaches the enable and edge-select registers through a simple write port and a registered read port.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the enable register and the edge-select register both read 0, and `irq_o` is low. No pin can raise the request until software sets an enable bit.
- R2: Writes with `wr_en_i` high land at the next clock edge. Address 0 holds the per-pin enables and address 1 holds the per-pin edge selects. `rd_data_o` shows the register at `rd_addr_i` one clock edge later. Any other address reads 0 and ignores writes.
- R3: With edge-select bit 0, a high-to-low transition on an enabled pin sets the request. A low-to-high transition on that pin does not.
- R4: With edge-select bit 1, a low-to-high transition on an enabled pin sets the request. A high-to-low transition on that pin does not.
- R5: A pin whose enable bit is 0 never sets the request, whichever way it changes.
- R6: While `gpio_global_en_i` is low, no pin sets the request. An edge that occurs while it is low is not remembered after the enable returns high.
- R7: A pin change applied before clock edge k sets `irq_o` at edge k+2, the third rising edge that sees the new level. `irq_o` is still low after edge k+1.
- R8: Once set, `irq_o` stays high until `irq_clr_i` is sampled high at a clock edge. With no new qualifying edge in that cycle, `irq_o` is low after that edge.
- R9: If a qualifying edge is due to set the request in the same cycle that `irq_clr_i` is high, `irq_o` is high after that edge.
- R10: Qualified edges from several pins, whether on one edge or on different edges, combine into the one request, and a single clear removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous GPIO input levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address (0 enable, 1 edge select) |
| wr_data_i | input | NPINS | Register write data, one bit per pin |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | NPINS | Registered read data |
| gpio_global_en_i | input | 1 | Global GPIO interrupt enable from the controller |
| irq_clr_i | input | 1 | Clears the sticky request |
| irq_o | output | 1 | Combined GPIO interrupt request |

## Verification
A pin change driven between edges first appears on `irq_o` after the third rising edge. The bench drives it at a falling edge, checks `irq_o` low after two rising edges, and checks the expected value after the third. Register writes and clear pulses act at the single rising edge within their one-cycle strobe. Read data and the cleared request are therefore sampled at the next falling edge. For the clear-collision case, the clear is raised in the cycle where the request is due to be set, which is the window after the second edge following the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register selects on the software port
  localparam int unsigned REG_ENABLE   = 0;
  localparam int unsigned REG_EDGE_SEL = 1;
  // Edge select encodings
  localparam logic EDGE_FALL = 1'b0;
  localparam logic EDGE_RISE = 1'b1;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q[0] <= '0;
    else       stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[s] <= '0;
      else       stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] edge_sel_i,
  output logic [WIDTH-1:0] event_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= level_i;
  end

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic went_up, went_down;
    assign went_up   =  level_i[p] & ~prev_q[p];
    assign went_down = ~level_i[p] &  prev_q[p];
    assign event_o[p] = (edge_sel_i[p] == EDGE_RISE) ? went_up : went_down;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic [WIDTH-1:0]  enable_o,
  output logic [WIDTH-1:0]  edge_sel_o
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(REG_ENABLE);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(REG_EDGE_SEL);

  logic [WIDTH-1:0] en_q, sel_q, rd_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_EN)  en_q  <= wr_data_i;
      if (wr_addr_i == A_SEL) sel_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else begin
      unique case (rd_addr_i)
        A_EN:    rd_q <= en_q;
        A_SEL:   rd_q <= sel_q;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o  = rd_q;
  assign enable_o   = en_q;
  assign edge_sel_o = sel_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NPINS-1:0]  rd_data_o,
  input  logic              gpio_global_en_i,
  input  logic              irq_clr_i,
  output logic              irq_o
);
  logic [NPINS-1:0] pin_sync, en_q, sel_q, pin_event;
  logic             hit, irq_q;

  gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .async_i(pin_i), .sync_o(pin_sync)
  );

  gpio_irq_regs #(.WIDTH(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .enable_o(en_q), .edge_sel_o(sel_q)
  );

  gpio_irq_edge #(.WIDTH(NPINS)) u_edge (
    .clk_i(clk_i), .rst_i(rst_i),
    .level_i(pin_sync), .edge_sel_i(sel_q), .event_o(pin_event)
  );

  // Pin enable and global enable must both be set
  assign hit = gpio_global_en_i & (|(pin_event & en_q));

  // Sticky request; a new hit wins over a clear in the same cycle
  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= (irq_q & ~irq_clr_i) | hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             gpio_global_en_i,
  input logic             irq_clr_i,
  input logic             irq_o,
  input logic [NPINS-1:0] en_q,
  input logic             hit
);
  AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> !irq_o); // R1
  AST_ENABLE_GATES: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_q == '0 && !irq_o) |=> !irq_o); // R5
  AST_GLOBAL_GATES: assert property (@(posedge clk_i) disable iff (rst_i)
    (!gpio_global_en_i && !irq_o) |=> !irq_o); // R6
  AST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o && !irq_clr_i) |=> irq_o); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_clr_i && !hit) |=> !irq_o); // R8
  AST_CLEAR_COLLIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_clr_i && hit) |=> irq_o); // R9
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .gpio_global_en_i(gpio_global_en_i),
  .irq_clr_i(irq_clr_i), .irq_o(irq_o), .en_q(en_q), .hit(hit)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
  localparam int NP = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [NP-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [NP-1:0] rd_data;
  logic          glb = 1'b0;
  logic          clr = 1'b0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_unit #(.NPINS(NP), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_i(rst), .pin_i(pins),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .gpio_global_en_i(glb), .irq_clr_i(clr), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung run, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [NP-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [NP-1:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rd_chk("R1 enable", 0, '0);
    rd_chk("R1 edge select", 1, '0);

    // R2 register access
    wr(0, 8'hA5); wr(1, 8'h3C);
    rd_chk("R2 enable", 0, 8'hA5);
    rd_chk("R2 edge select", 1, 8'h3C);
    wr(2, 8'hFF);
    rd_chk("R2 unused addr", 2, '0);
    rd_chk("R2 enable kept", 0, 8'hA5);
    rd_chk("R2 edge kept", 1, 8'h3C);
    wr(0, '0); wr(1, '0);
    pulse_clr();

    // Sweep: pin x edge select x enable x global x direction
    for (int p = 0; p < NP; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int en = 0; en < 2; en++)
          for (int g = 0; g < 2; g++)
            for (int dir = 0; dir < 2; dir++) begin
              logic exp;
              string req;
              wr(0, '0);
              @(negedge clk); pins = (dir == 1) ? '0 : (NP'(1) << p);
              repeat (4) @(negedge clk);
              glb = g[0];
              wr(1, pol[0] ? (NP'(1) << p) : '0);
              wr(0, en[0] ? (NP'(1) << p) : '0);
              pulse_clr();
              exp = en[0] & g[0] & (pol == dir);
              if (en == 0)     req = "R5";
              else if (g == 0) req = "R6";
              else if (pol==1) req = "R4";
              else             req = "R3";
              pins = pins ^ (NP'(1) << p);
              repeat (2) @(negedge clk);
              if (exp) chk("R7 early", 32'(irq), 0);
              @(negedge clk);
              chk(req, 32'(irq), 32'(exp));
              if (exp) begin
                repeat (3) @(negedge clk);
                chk("R8 sticky", 32'(irq), 1);
                pulse_clr();
                chk("R8 clear", 32'(irq), 0);
              end
            end

    // R6: edge while global enable is low is not remembered
    wr(0, '0); @(negedge clk); pins = '0; repeat (4) @(negedge clk);
    wr(1, 8'hFF); wr(0, 8'h01); glb = 1'b0; pulse_clr();
    pins = 8'h01; repeat (4) @(negedge clk);
    glb = 1'b1; repeat (4) @(negedge clk);
    chk("R6 not remembered", 32'(irq), 0);

    // R9: clear in the cycle the request is due
    pins = 8'h00; repeat (4) @(negedge clk);
    pins = 8'h01; repeat (4) @(negedge clk);
    chk("R9 setup", 32'(irq), 1);
    pins = 8'h00; repeat (4) @(negedge clk);
    pins = 8'h01; repeat (2) @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R9 collide", 32'(irq), 1);
    pulse_clr();
    chk("R9 clear alone", 32'(irq), 0);

    // R10: several pins into one request
    wr(0, '0); @(negedge clk); pins = '0; repeat (4) @(negedge clk);
    wr(0, 8'h24); pulse_clr();
    pins = 8'h20; repeat (3) @(negedge clk);
    chk("R10 pin5", 32'(irq), 1);
    pins = 8'h24; repeat (3) @(negedge clk);
    chk("R10 pin2 later", 32'(irq), 1);
    pulse_clr();
    chk("R10 one clear", 32'(irq), 0);
    pins = 8'h00; repeat (4) @(negedge clk);
    pins = 8'h24; repeat (3) @(negedge clk);
    chk("R10 both", 32'(irq), 1);
    pulse_clr();
    chk("R10 clear both", 32'(irq), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule